// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Gate

This block sits between a byte-wide host register bus and an engine that runs enhanced-parallel-port transfers on the cable. It keeps a copy of the port control register and a copy of the output data latch. It forwards an address cycle or a data cycle to the engine only when the stored control lines select the correct direction and signal state for that cycle. Any other cycle is dropped on the spot. It also keeps a sticky timeout flag, which is set when the engine reports a failed cycle and is shown in bit 0 of the status register.

The host starts an access by raising `hostSel` and holds the address, size and write data stable until `hostReady` is high. An access that the bridge answers locally completes in the cycle it is presented. An access that is forwarded raises `engReq` on the next clock edge and waits for `engAck`. Only one engine request is outstanding at a time. Writes that would not change the control or data latch are not forwarded, so the engine is not kept busy for nothing.

Top module: `epp_gate_bridge`

## Requirements
- R1: After reset the control register reads 0x0C, the data latch reads 0xFF, status bit 0 (timeout) reads 0, and `engReq` is low.
- R2: A control write (offset 2) is stored with bits 7:6 forced to 1 and reads back so. It is forwarded (engKind=3, engWdata = the stored byte) only when the stored value changes.
- R3: A data-latch write (offset 0) is forwarded (engKind=2, engWdata = the byte) only when the byte differs from the stored latch. A read of offset 0 returns the stored latch.
- R4: A write to offset 3 (engKind=0) or offset 4 (engKind=1) is forwarded only when control AND 0x2F equals 0x04. Otherwise it completes at once with no request.
- R5: A read of offset 3 or 4 is forwarded (engRead=1) only when control AND 0x2F equals 0x24. Otherwise it completes at once and returns all ones at the access width.
- R6: An engine error on a forwarded address or data cycle sets the timeout flag. It stays set across later accesses. A status read (offset 1) returns {lineStatus[7:1], flag}.
- R7: A status write with bit 0 = 1 clears the timeout flag. A status write with bit 0 = 0 leaves it unchanged.
- R8: Offset 4 accepts hostSize 0 (byte), 1 (16-bit) or 2/3 (32-bit), with byte 0 in bits 7:0 and carried first. engSize equals the access size, and engWdata and the returned read data are masked to that width. Every other offset uses byte size.
- R9: An address with any nonzero bit above bit 2 (including the second window at 0x400) is ignored. A write changes no state and sends no request. A read returns 0xFF.
- R10: While a request is outstanding, `hostReady` stays low until `engAck`. `engReq` stays high and its kind, direction, size and data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Host access request, held until hostReady |
| hostWrite | input | 1 | 1 = write, 0 = read |
| hostAddr | input | ADDR_W | Byte address; bits 2:0 select the register |
| hostSize | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit (offset 4 only) |
| hostWdata | input | 32 | Write data, little-endian |
| hostRdata | output | 32 | Read data, valid when hostReady is high |
| hostReady | output | 1 | Access completes this cycle |
| lineStatus | input | 7 | Cable status lines shown in status bits 7:1 |
| engReq | output | 1 | Engine request outstanding |
| engKind | output | 2 | 0 address cycle, 1 data cycle, 2 latch write, 3 control write |
| engRead | output | 1 | Request is a read |
| engSize | output | 2 | Transfer size code |
| engWdata | output | 32 | Request write data |
| engAck | input | 1 | Engine response, valid while engReq |
| engRdata | input | 32 | Engine read data |
| engErr | input | 1 | Engine reports the cycle failed |

## Verification
The assertions check on every cycle that a forwarded write or read cycle matches its control-line pattern, and that a stored control value always carries bits 7:6. They also check that the timeout flag rises only after an engine error and that an outstanding request holds steady until it is acknowledged. Write suppression, width masking, the clear-by-one status write and the ignored address windows show only in the bench's scenarios. The bench compares those with its reference model after each access, and it compares `engReq` with the model's expected busy state on every clock.

// File: rtl/epp_gate_pkg.sv
package epp_gate_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 3;

  localparam logic [OFF_W-1:0] OFF_LATCH    = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STATUS   = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CONTROL  = 3'd2;
  localparam logic [OFF_W-1:0] OFF_EPP_ADDR = 3'd3;
  localparam logic [OFF_W-1:0] OFF_EPP_DATA = 3'd4;

  localparam logic [7:0] GATE_MASK   = 8'h2F;
  localparam logic [7:0] WR_PATTERN  = 8'h04;
  localparam logic [7:0] RD_PATTERN  = 8'h24;
  localparam logic [7:0] CTRL_RESET  = 8'h0C;
  localparam logic [7:0] CTRL_FORCE  = 8'hC0;
  localparam logic [7:0] LATCH_RESET = 8'hFF;

  typedef enum logic [1:0] {
    KIND_ADDR  = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_LATCH = 2'd2,
    KIND_CTRL  = 2'd3
  } kind_e;

  typedef enum logic [2:0] {
    SEL_ONES, SEL_LATCH, SEL_STAT, SEL_CTRL, SEL_ENG
  } rdsel_e;

  typedef struct packed {
    logic       issue;
    kind_e      kind;
    logic       isRead;
    logic [1:0] size;
    logic       latchLoad;
    logic       ctrlLoad;
    logic       clrTimeout;
    logic       respDone;
    rdsel_e     rdSel;
  } strobe_t;

  function automatic logic [DATA_W-1:0] laneMask(input logic [1:0] sz);
    case (sz)
      2'd0:    return {{(DATA_W-8){1'b0}}, 8'hFF};
      2'd1:    return {{(DATA_W-16){1'b0}}, 16'hFFFF};
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/epp_gate_ctrl.sv
module epp_gate_ctrl
  import epp_gate_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic              clrBit,
  input  logic              ctrlSame,
  input  logic              latchSame,
  input  logic              wrGateOk,
  input  logic              rdGateOk,
  input  logic              engAck,
  output strobe_t           stb,
  output logic              hostReady,
  output logic              busy
);
  logic             nextBusy;
  logic             outside;
  logic [OFF_W-1:0] off;
  logic             eppOff;

  assign outside = |hostAddr[ADDR_W-1:OFF_W];
  assign off     = hostAddr[OFF_W-1:0];
  assign eppOff  = (off == OFF_EPP_ADDR) || (off == OFF_EPP_DATA);

  always_comb begin
    stb       = '0;
    stb.kind  = KIND_ADDR;
    stb.rdSel = SEL_ONES;
    hostReady = 1'b0;
    nextBusy  = busy;
    if (busy) begin
      stb.rdSel    = SEL_ENG;
      stb.respDone = engAck;
      hostReady    = engAck;
      if (engAck) nextBusy = 1'b0;
    end else if (hostSel) begin
      hostReady = 1'b1;
      stb.size  = (!outside && off == OFF_EPP_DATA) ? hostSize : 2'd0;
      if (!outside) begin
        if (hostWrite) begin
          if (off == OFF_LATCH && !latchSame) begin
            stb.issue     = 1'b1;
            stb.kind      = KIND_LATCH;
            stb.latchLoad = 1'b1;
          end
          if (off == OFF_STATUS) stb.clrTimeout = clrBit;
          if (off == OFF_CONTROL && !ctrlSame) begin
            stb.issue    = 1'b1;
            stb.kind     = KIND_CTRL;
            stb.ctrlLoad = 1'b1;
          end
          if (eppOff && wrGateOk) begin
            stb.issue = 1'b1;
            stb.kind  = (off == OFF_EPP_ADDR) ? KIND_ADDR : KIND_DATA;
          end
        end else begin
          case (off)
            OFF_LATCH:   stb.rdSel = SEL_LATCH;
            OFF_STATUS:  stb.rdSel = SEL_STAT;
            OFF_CONTROL: stb.rdSel = SEL_CTRL;
            default:     stb.rdSel = SEL_ONES;
          endcase
          if (eppOff && rdGateOk) begin
            stb.issue  = 1'b1;
            stb.isRead = 1'b1;
            stb.kind   = (off == OFF_EPP_ADDR) ? KIND_ADDR : KIND_DATA;
          end
        end
      end
      if (stb.issue) begin
        hostReady = 1'b0;
        nextBusy  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) busy <= 1'b0;
    else       busy <= nextBusy;
  end

  // R10: a host access that started a request is not completed in the issue cycle
  assert_no_early_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && hostSel && stb.issue) |=> (busy && (hostReady == engAck)));
endmodule

// File: rtl/epp_gate_dp.sv
module epp_gate_dp
  import epp_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              busy,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [7:1]        lineStatus,
  input  logic [DATA_W-1:0] engRdata,
  input  logic              engErr,
  output logic [DATA_W-1:0] hostRdata,
  output kind_e             reqKind,
  output logic              reqRead,
  output logic [1:0]        reqSize,
  output logic [DATA_W-1:0] reqData,
  output logic              ctrlSame,
  output logic              latchSame,
  output logic              wrGateOk,
  output logic              rdGateOk
);
  logic [7:0] ctrlShadow;
  logic [7:0] latchShadow;
  logic       timeoutFlag;
  logic [7:0] ctrlForced;
  logic       eppKind;

  assign ctrlForced = hostWdata[7:0] | CTRL_FORCE;
  assign ctrlSame   = (ctrlForced == ctrlShadow);
  assign latchSame  = (hostWdata[7:0] == latchShadow);
  assign wrGateOk   = ((ctrlShadow & GATE_MASK) == WR_PATTERN);
  assign rdGateOk   = ((ctrlShadow & GATE_MASK) == RD_PATTERN);
  assign eppKind    = (reqKind == KIND_ADDR) || (reqKind == KIND_DATA);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlShadow  <= CTRL_RESET;
      latchShadow <= LATCH_RESET;
      timeoutFlag <= 1'b0;
      reqKind     <= KIND_ADDR;
      reqRead     <= 1'b0;
      reqSize     <= 2'd0;
      reqData     <= '0;
    end else begin
      if (stb.ctrlLoad)  ctrlShadow  <= ctrlForced;
      if (stb.latchLoad) latchShadow <= hostWdata[7:0];
      if (stb.respDone && engErr && eppKind) timeoutFlag <= 1'b1;
      else if (stb.clrTimeout)               timeoutFlag <= 1'b0;
      if (stb.issue) begin
        reqKind <= stb.kind;
        reqRead <= stb.isRead;
        reqSize <= stb.size;
        reqData <= (stb.kind == KIND_CTRL) ? {{(DATA_W-8){1'b0}}, ctrlForced}
                                           : (hostWdata & laneMask(stb.size));
      end
    end
  end

  always_comb begin
    case (stb.rdSel)
      SEL_LATCH: hostRdata = {{(DATA_W-8){1'b0}}, latchShadow};
      SEL_STAT:  hostRdata = {{(DATA_W-8){1'b0}}, lineStatus, timeoutFlag};
      SEL_CTRL:  hostRdata = {{(DATA_W-8){1'b0}}, ctrlShadow};
      SEL_ENG:   hostRdata = engRdata & laneMask(reqSize);
      default:   hostRdata = laneMask(stb.size);
    endcase
  end

  assert_ctrl_forced_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctrlShadow) |-> (ctrlShadow[7:6] == 2'b11));

  assert_write_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && eppKind && !reqRead) |-> ((ctrlShadow & GATE_MASK) == WR_PATTERN));

  assert_read_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && reqRead) |-> ((ctrlShadow & GATE_MASK) == RD_PATTERN));

  assert_timeout_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutFlag) |-> $past(busy && engErr));

  assert_req_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !stb.respDone) |=> (busy && $stable(reqData) && $stable(reqKind)
                                 && $stable(reqSize) && $stable(reqRead)));
endmodule

// File: rtl/epp_gate_bridge.sv
module epp_gate_bridge
  import epp_gate_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostSel,
  input  logic              hostWrite,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [1:0]        hostSize,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              hostReady,
  input  logic [7:1]        lineStatus,
  output logic              engReq,
  output logic [1:0]        engKind,
  output logic              engRead,
  output logic [1:0]        engSize,
  output logic [31:0]       engWdata,
  input  logic              engAck,
  input  logic [31:0]       engRdata,
  input  logic              engErr
);
  strobe_t stb;
  logic    busy;
  logic    ctrlSame, latchSame, wrGateOk, rdGateOk;
  kind_e   reqKind;

  epp_gate_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize), .clrBit(hostWdata[0]),
    .ctrlSame(ctrlSame), .latchSame(latchSame), .wrGateOk(wrGateOk),
    .rdGateOk(rdGateOk), .engAck(engAck), .stb(stb), .hostReady(hostReady),
    .busy(busy)
  );

  epp_gate_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busy(busy), .hostWdata(hostWdata),
    .lineStatus(lineStatus), .engRdata(engRdata), .engErr(engErr),
    .hostRdata(hostRdata), .reqKind(reqKind), .reqRead(engRead),
    .reqSize(engSize), .reqData(engWdata), .ctrlSame(ctrlSame),
    .latchSame(latchSame), .wrGateOk(wrGateOk), .rdGateOk(rdGateOk)
  );

  assign engReq  = busy;
  assign engKind = reqKind;
endmodule

// File: tb/epp_gate_bridge_tb.sv
`timescale 1ns/100ps
module epp_gate_bridge_tb;
  logic        clk = 1'b0, rstN = 1'b0;
  logic        hostSel = 0, hostWrite = 0;
  logic [10:0] hostAddr = '0;
  logic [1:0]  hostSize = '0;
  logic [31:0] hostWdata = '0, hostRdata, engWdata, engRdata = '0;
  logic        hostReady, engReq, engRead, engAck = 0, engErr = 0;
  logic [1:0]  engKind, engSize;
  logic [7:1]  lineStatus = 7'b1010011;

  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] mCtrl = 8'h0C, mLatch = 8'hFF;
  bit mTo = 0, expBusy = 0, monOn = 0;

  always #2.5 clk = ~clk;

  epp_gate_bridge u_dut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWrite(hostWrite),
    .hostAddr(hostAddr), .hostSize(hostSize), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostReady(hostReady), .lineStatus(lineStatus),
    .engReq(engReq), .engKind(engKind), .engRead(engRead), .engSize(engSize),
    .engWdata(engWdata), .engAck(engAck), .engRdata(engRdata), .engErr(engErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] lm(input logic [1:0] sz);
    return (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // R10: every clock, the request line follows the model's busy state
  always @(negedge clk) if (monOn) chk("R10 engReq per clock", {31'd0, engReq}, {31'd0, expBusy});

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Reference model of one host access; called at a falling edge.
  task automatic access(input bit wr, input logic [10:0] addr, input logic [1:0] sz,
                        input logic [31:0] wd, input int dly, input logic [31:0] ed,
                        input bit err, input string req);
    bit outside = (addr[10:3] != 0);
    logic [2:0] off = addr[2:0];
    logic [1:0] es = (!outside && off == 3'd4) ? sz : 2'd0;
    bit fwd = 0, setCtrl = 0, setLatch = 0, clrTo = 0;
    logic [1:0] kind = 0;
    logic [31:0] expWd = 0, expRd = lm(es);
    if (!outside) begin
      if (wr) begin
        if (off == 0 && wd[7:0] != mLatch) begin fwd = 1; kind = 2; expWd = {24'd0, wd[7:0]}; setLatch = 1; end
        if (off == 1) clrTo = wd[0];
        if (off == 2 && (wd[7:0] | 8'hC0) != mCtrl) begin fwd = 1; kind = 3; expWd = {24'd0, wd[7:0] | 8'hC0}; setCtrl = 1; end
        if ((off == 3 || off == 4) && (mCtrl & 8'h2F) == 8'h04) begin fwd = 1; kind = off - 3; expWd = wd & lm(es); end
      end else begin
        if (off == 0) expRd = {24'd0, mLatch};
        if (off == 1) expRd = {24'd0, lineStatus, mTo};
        if (off == 2) expRd = {24'd0, mCtrl};
        if ((off == 3 || off == 4) && (mCtrl & 8'h2F) == 8'h24) begin fwd = 1; kind = off - 3; expRd = ed & lm(es); end
      end
    end
    hostSel = 1; hostWrite = wr; hostAddr = addr; hostSize = sz; hostWdata = wd;
    #1;
    if (!fwd) begin
      chk({req, " local ready"}, {31'd0, hostReady}, 32'd1);
      if (!wr) chk({req, " local rdata"}, hostRdata, expRd);
      @(posedge clk);
      if (clrTo) mTo = 0;
      @(negedge clk);
      hostSel = 0;
    end else begin
      chk({req, " R10 ready low at issue"}, {31'd0, hostReady}, 32'd0);
      @(posedge clk);
      expBusy = 1;
      if (setCtrl) mCtrl = wd[7:0] | 8'hC0;
      if (setLatch) mLatch = wd[7:0];
      @(negedge clk);
      chk({req, " kind"}, {30'd0, engKind}, {30'd0, kind});
      chk({req, " dir"}, {31'd0, engRead}, {31'd0, !wr});
      chk({req, " size"}, {30'd0, engSize}, {30'd0, es});
      if (wr) chk({req, " wdata"}, engWdata, expWd);
      for (int i = 0; i < dly; i++) begin
        #1 chk({req, " R10 wait ready"}, {31'd0, hostReady}, 32'd0);
        @(negedge clk);
      end
      engAck = 1; engRdata = ed; engErr = err;
      #1 chk({req, " ack ready"}, {31'd0, hostReady}, 32'd1);
      if (!wr) chk({req, " engine rdata"}, hostRdata, expRd);
      @(posedge clk);
      expBusy = 0;
      if (err && kind < 2) mTo = 1;
      @(negedge clk);
      engAck = 0; engErr = 0; hostSel = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] dummy;
    repeat (4) @(negedge clk);
    rstN = 1;
    monOn = 1;
    @(negedge clk);
    // R1 reset state
    access(0, 11'h002, 0, 0, 0, 0, 0, "R1 ctrl reset");
    access(0, 11'h000, 0, 0, 0, 0, 0, "R1 latch reset");
    access(0, 11'h001, 0, 0, 0, 0, 0, "R1 status reset");
    // R4/R5 blocked at reset pattern
    access(1, 11'h004, 2, 32'hCAFEF00D, 0, 0, 0, "R4 dropped write");
    access(0, 11'h004, 1, 0, 0, 0, 0, "R5 blocked read 16");
    // R2 control write and suppression
    access(1, 11'h002, 0, 32'h04, 1, 0, 0, "R2 ctrl write");
    access(1, 11'h002, 0, 32'hC4, 0, 0, 0, "R2 ctrl same");
    access(0, 11'h002, 0, 0, 0, 0, 0, "R2 ctrl readback");
    // R4/R8 forwarded writes
    access(1, 11'h003, 0, 32'h1234565A, 0, 0, 0, "R4 addr write");
    access(1, 11'h004, 1, 32'h1234ABCD, 2, 0, 0, "R8 data write 16");
    access(1, 11'h004, 2, 32'h89ABCDEF, 3, 0, 0, "R8 data write 32");
    access(0, 11'h004, 2, 0, 0, 0, 0, "R5 read blocked in write mode");
    // R3 latch
    access(1, 11'h000, 0, 32'h55, 0, 0, 0, "R3 latch write");
    access(1, 11'h000, 0, 32'hFF55, 0, 0, 0, "R3 latch same");
    access(0, 11'h000, 0, 0, 0, 0, 0, "R3 latch read");
    // R5 read mode
    access(1, 11'h002, 0, 32'h24, 0, 0, 0, "R2 ctrl to read mode");
    access(1, 11'h004, 0, 32'h11, 0, 0, 0, "R4 write blocked in read mode");
    access(0, 11'h004, 2, 0, 1, 32'hDEADBEEF, 0, "R8 read 32");
    access(0, 11'h004, 1, 0, 0, 32'h11223344, 0, "R8 read 16");
    access(0, 11'h003, 0, 0, 2, 32'hAABBCC77, 0, "R5 addr read");
    // R6/R7 timeout
    access(0, 11'h004, 0, 0, 1, 32'h99, 1, "R6 error read");
    access(0, 11'h001, 0, 0, 0, 0, 0, "R6 status flag set");
    access(0, 11'h000, 0, 0, 0, 0, 0, "R6 other access");
    access(1, 11'h001, 0, 32'hFE, 0, 0, 0, "R7 status write bit0 0");
    access(0, 11'h001, 0, 0, 0, 0, 0, "R7 flag kept");
    access(1, 11'h001, 0, 32'h01, 0, 0, 0, "R7 status write bit0 1");
    access(0, 11'h001, 0, 0, 0, 0, 0, "R7 flag cleared");
    // R5 select line blocks reads
    access(1, 11'h002, 0, 32'h2C, 0, 0, 0, "R2 ctrl select set");
    access(0, 11'h004, 0, 0, 0, 0, 0, "R5 blocked by select");
    // R9 ignored windows
    access(1, 11'h402, 0, 32'h00, 0, 0, 0, "R9 alt write");
    access(1, 11'h008, 0, 32'h00, 0, 0, 0, "R9 mid-bit write");
    access(0, 11'h002, 0, 0, 0, 0, 0, "R9 ctrl unchanged");
    access(0, 11'h404, 2, 0, 0, 0, 0, "R9 alt read");
    monOn = 0;
    dummy = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule